// File: doc/BRIEF.md
# Quadrature Edge-Phase FSK Demodulator

This block turns two hard-limited baseband channels from a zero-IF receiver, an in-phase channel and a quadrature channel, into a binary FSK data stream. Both square-wave inputs are brought into the system clock domain. Every rising and falling transition on either channel then produces one phase decision. At each transition the block looks at the level of the other channel and works out whether the in-phase signal leads or lags the quadrature signal. With four transitions per IF cycle, the output can change four times per IF period. The worst-case output jitter is therefore a quarter of an IF period when there is no frequency offset.

A tone above the local oscillator makes the in-phase channel lag, and the block reports a one. A tone below it makes the in-phase channel lead, and the block reports a zero. The block keeps a short history of decisions and drives a voted output from it. A control input widens the vote from the newest three decisions to the newest seven, which gives more smoothing at low bit rates.

Top module: `iq_edge_demod`

## Requirements
- R1: While `rst_n` is low, `raw_bit` and `data_out` are 0 and the decision history is cleared to all zeros.
- R2: A transition on `i_lim` alone gives a decision of 1 when the new `i_lim` level equals the `q_lim` level, and 0 otherwise. `raw_bit` shows the decision on the third rising clock edge after the input change and keeps its old value at the second.
- R3: A transition on `q_lim` alone gives a decision of 1 when the new `q_lim` level differs from the `i_lim` level, and 0 otherwise. The latency is the same as in R2.
- R4: When both inputs change in the same cycle, no decision is recorded, and `raw_bit` and `data_out` keep their values.
- R5: While neither input changes, `raw_bit` and `data_out` keep their values.
- R6: With `smooth_en` = 0, `data_out` is 1 exactly when at least 2 of the 3 newest decisions are 1.
- R7: With `smooth_en` = 1, `data_out` is 1 exactly when at least 4 of the 7 newest decisions are 1. A change of `smooth_en` shows on `data_out` in the same cycle.
- R8: A continuous quadrature pattern in which `q_lim` leads `i_lim` drives both outputs to 1. The opposite rotation drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_lim | input | 1 | In-phase limiter output, asynchronous |
| q_lim | input | 1 | Quadrature limiter output, asynchronous |
| smooth_en | input | 1 | Selects the 7-decision vote instead of the 3-decision vote |
| raw_bit | output | 1 | Newest edge decision |
| data_out | output | 1 | Majority-voted data |

## Verification
The bench uses the default build: a two-flop synchroniser, a 3-decision short vote and a 7-decision long vote. These sizes are small enough that the bench can step through all sixteen transitions between input level pairs, both rotation senses, and random phase slips that include simultaneous transitions. It runs each of these with both vote widths. The bench keeps its own seven-entry history and recomputes both majorities arithmetically after every step. It checks each step one cycle before and at the cycle the output is expected to change, which pins the latency exactly.

// File: rtl/iq_edge_demod.sv
module iq_edge_demod #(
  parameter int SYNC_DEPTH = 2,
  parameter int SHORT_TAPS = 3,
  parameter int LONG_TAPS  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i_lim,
  input  logic q_lim,
  input  logic smooth_en,
  output logic raw_bit,
  output logic data_out
);
  localparam int SHORT_NEED = SHORT_TAPS / 2 + 1;
  localparam int LONG_NEED  = LONG_TAPS / 2 + 1;

  logic [SYNC_DEPTH-1:0] i_sync, q_sync;
  logic                  i_prev, q_prev;
  logic [LONG_TAPS-1:0]  hist;

  wire i_now  = i_sync[SYNC_DEPTH-1];
  wire q_now  = q_sync[SYNC_DEPTH-1];
  wire i_edge = i_now ^ i_prev;
  wire q_edge = q_now ^ q_prev;
  wire take   = i_edge ^ q_edge;
  wire dec    = i_edge ? ~(i_now ^ q_now) : (i_now ^ q_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_sync <= '0;
      q_sync <= '0;
      i_prev <= 1'b0;
      q_prev <= 1'b0;
      hist   <= '0;
    end else begin
      i_sync <= {i_sync[SYNC_DEPTH-2:0], i_lim};
      q_sync <= {q_sync[SYNC_DEPTH-2:0], q_lim};
      i_prev <= i_now;
      q_prev <= q_now;
      if (take) hist <= {hist[LONG_TAPS-2:0], dec};
    end
  end

  int short_cnt, long_cnt;
  always_comb begin
    short_cnt = 0;
    long_cnt  = 0;
    for (int k = 0; k < LONG_TAPS; k++) begin
      if (hist[k]) begin
        long_cnt = long_cnt + 1;
        if (k < SHORT_TAPS) short_cnt = short_cnt + 1;
      end
    end
  end

  assign raw_bit  = hist[0];
  assign data_out = smooth_en ? (long_cnt >= LONG_NEED) : (short_cnt >= SHORT_NEED);

  p_i_rise_q_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_edge && !q_edge && i_now && q_now) |=> raw_bit);
  p_i_fall_q_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_edge && !q_edge && !i_now && q_now) |=> !raw_bit);
  p_q_rise_i_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_edge && !i_edge && q_now && !i_now) |=> raw_bit);
  p_q_rise_i_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_edge && !i_edge && q_now && i_now) |=> !raw_bit);
  p_both_edges_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (i_edge && q_edge) |=> $stable(hist));
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_edge && !q_edge) |=> $stable(hist));
  p_short_vote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!smooth_en && $countones(hist[SHORT_TAPS-1:0]) == SHORT_TAPS) |-> data_out);
  p_long_vote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smooth_en && $countones(hist) < LONG_NEED) |-> !data_out);
endmodule

// File: tb/iq_edge_demod_bench.sv
module iq_edge_demod_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_lim = 1'b0, q_lim = 1'b0, smooth_en = 1'b0;
  logic raw_bit, data_out;
  int checks = 0, failures = 0;
  logic [6:0] mh = '0;
  logic cur_i = 1'b0, cur_q = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  iq_edge_demod u_iq_edge_demod (
    .clk(clk), .rst_n(rst_n), .i_lim(i_lim), .q_lim(q_lim),
    .smooth_en(smooth_en), .raw_bit(raw_bit), .data_out(data_out));

  function automatic logic vote();
    int c3 = 0, c7 = 0;
    for (int k = 0; k < 7; k++) if (mh[k]) begin c7++; if (k < 3) c3++; end
    return smooth_en ? (c7 >= 4) : (c3 >= 2);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(logic ni, logic nq, string req);
    logic old_raw = mh[0];
    logic old_vote = vote();
    bool_upd: begin
      if ((ni != cur_i) && (nq == cur_q)) mh = {mh[5:0], ~(ni ^ nq)};
      else if ((nq != cur_q) && (ni == cur_i)) mh = {mh[5:0], ni ^ nq};
    end
    cur_i = ni; cur_q = nq;
    i_lim = ni; q_lim = nq;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({req, " R2 pre-latency raw"}, raw_bit, old_raw);
    chk({req, " R6 pre-latency vote"}, data_out, old_vote);
    @(posedge clk); @(negedge clk);
    chk({req, " raw"}, raw_bit, mh[0]);
    chk({req, smooth_en ? " R7 vote" : " R6 vote"}, data_out, vote());
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed = 11;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 raw in reset", raw_bit, 1'b0);
    chk("R1 vote in reset", data_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      smooth_en = m[0];
      // R8: q leads i -> ones
      for (int n = 0; n < 12; n++)
        case (n % 4)
          0: step(0, 1, "R8 R3 cw");
          1: step(1, 1, "R8 R2 cw");
          2: step(1, 0, "R8 R3 cw");
          default: step(0, 0, "R8 R2 cw");
        endcase
      chk("R8 cw raw", raw_bit, 1'b1);
      chk("R8 cw vote", data_out, 1'b1);
      for (int n = 0; n < 12; n++)
        case (n % 4)
          0: step(1, 0, "R8 R2 ccw");
          1: step(1, 1, "R8 R3 ccw");
          2: step(0, 1, "R8 R2 ccw");
          default: step(0, 0, "R8 R3 ccw");
        endcase
      chk("R8 ccw raw", raw_bit, 1'b0);
      chk("R8 ccw vote", data_out, 1'b0);
      // all sixteen level-pair transitions
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          step(a[1], a[0], "R2 R3 R4 R5 sweep-from");
          step(b[1], b[0], "R2 R3 R4 R5 sweep-to");
        end
      // random phase slips
      for (int n = 0; n < 300; n++) begin
        int op = $urandom_range(0, 5);
        case (op)
          0, 1: step(cur_q ? ~cur_i : cur_i, cur_q ? cur_q : ~cur_q, "R8 slip");
          2: step(~cur_i, cur_q, "R2 slip");
          3: step(cur_i, ~cur_q, "R3 slip");
          4: step(~cur_i, ~cur_q, "R4 slip both");
          default: step(cur_i, cur_q, "R5 slip quiet");
        endcase
      end
    end
    // R7: vote width switch takes effect without new edges
    for (int n = 0; n < 8; n++) begin
      smooth_en = n[0];
      @(negedge clk);
      chk("R7 mode switch", data_out, vote());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule